// File: doc/BRIEF.md
# Six-Operand Carry-Save Compressor Row

This block adds six unsigned W-bit operands in a single combinational pass. One compressor cell sits in every bit column. It folds the column's six data bits and two incoming carry bits into two result bits. One result bit keeps the column's own weight and the other has twice that weight. What comes out is a redundant pair of vectors whose sum is the total of the six operands. Every column contributes two bits to the pair.

Each cell produces two carry bits for the columns above it. Both are functions of its own six data bits only. The near carry has twice the column weight and enters the next column. The far carry has four times the column weight and enters the column two places up. No carry-in reaches any carry-out, so linking the cells adds no rippling delay. Two extra cells above the operand width take in the top carries. The pair is therefore W+3 bits wide and never loses a bit.

A build-time switch, `FINAL_ADD`, adds a plain ripple adder behind the pair so that the row also gives the binary total. With the switch off, that output stays at zero and only the redundant pair is meaningful.

Top module: `csa_row6`

## Requirements
- R1: Operand k (k = 0..5) occupies bits [k·W +: W] of `ops`, and all operands are unsigned.
- R2: In every column j, the count of set data bits plus the near carry from column j−1 plus the far carry from column j−2 equals the column's low result bit plus twice its high result bit plus twice its near carry-out plus four times its far carry-out. Missing lower columns supply 0.
- R3: A column's carry-outs depend only on its own six data bits. So `sum_vec[j]` and `carry_vec[j+1]` depend only on the data of columns j, j−1 and j−2. A change confined to column 0 leaves `sum_vec[W+2:3]` and `carry_vec[W+2:4]` unchanged.
- R4: `sum_vec + carry_vec`, taken modulo 2^(W+3), equals the exact sum of the six operands for every input.
- R5: `carry_vec[0]` is always 0 and `sum_vec[W+2]` is always 0.
- R6: With `FINAL_ADD` = 1, `total` equals the exact sum of the six operands.
- R7: With `FINAL_ADD` = 0, `total` is 0 for every input, and R4 still holds for the pair.
- R8: Six operands of all ones give 6·(2^W − 1) on both the pair and `total`, with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ops | input | 6*W | Six packed unsigned operands, operand 0 in the lowest W bits |
| sum_vec | output | W+3 | Low-weight result bit of every column, bit j from column j |
| carry_vec | output | W+3 | High-weight result bit of every column, bit j+1 from column j |
| total | output | W+3 | Binary sum of the pair when FINAL_ADD = 1, otherwise zero |

## Verification
The hardest case to reach is a column that sees a heavy data pattern while both incoming carries are set. Those carries are fixed by lower columns, so no port sets them directly. The bench drives every one of the 4096 input words of a two-bit-wide row. That sweep covers each column-0 and column-1 data pattern and every near-carry value, and the extension columns receive both carries at once. Long random runs on an eight-bit row, all-ones operands and a single-column toggle then cover the far carry into data-carrying columns and the locality of the carries.

// File: rtl/csa_row6.sv
module csa_row6 #(
  parameter int W = 8,
  parameter bit FINAL_ADD = 1'b1
) (
  input  logic [6*W-1:0] ops,
  output logic [W+2:0]   sum_vec,
  output logic [W+2:0]   carry_vec,
  output logic [W+2:0]   total
);
  localparam int RW = W + 3;
  localparam int NC = W + 2;

  logic [NC-1:0] lo_bit, hi_bit, near_co, far_co;

  for (genvar j = 0; j < NC; j++) begin : g_col
    logic [5:0] dat;
    logic cin_near, cin_far;
    logic s_a, c_a, s_b, c_b, lo, h;

    for (genvar k = 0; k < 6; k++) begin : g_bit
      if (j < W) begin : g_live
        assign dat[k] = ops[k*W + j];
      end else begin : g_pad
        assign dat[k] = 1'b0;
      end
    end

    if (j == 0) begin : g_c0
      assign cin_near = 1'b0;
    end else begin : g_cn
      assign cin_near = near_co[j-1];
    end
    if (j < 2) begin : g_f0
      assign cin_far = 1'b0;
    end else begin : g_fn
      assign cin_far = far_co[j-2];
    end

    assign s_a = dat[0] ^ dat[1] ^ dat[2];
    assign c_a = (dat[0] & dat[1]) | (dat[2] & (dat[0] ^ dat[1]));
    assign s_b = dat[3] ^ dat[4] ^ dat[5];
    assign c_b = (dat[3] & dat[4]) | (dat[5] & (dat[3] ^ dat[4]));
    assign lo  = s_a ^ s_b;
    assign h   = s_a & s_b;

    assign near_co[j] = c_a ^ c_b ^ h;
    assign far_co[j]  = (c_a & c_b) | (h & (c_a ^ c_b));

    assign lo_bit[j] = lo ^ cin_near ^ cin_far;
    assign hi_bit[j] = (lo & cin_near) | (cin_far & (lo ^ cin_near));

    always_comb begin
      p_cell_identity_r2: assert (4'($countones(dat)) + 4'(cin_near) + 4'(cin_far)
                                  == 4'(lo_bit[j]) + 4'({hi_bit[j], 1'b0})
                                   + 4'({near_co[j], 1'b0}) + 4'({far_co[j], 2'b00}))
        else $error("column %0d identity broken", j);
      p_cout_data_only_r3: assert ({far_co[j], near_co[j]} == 2'($countones(dat) >> 1))
        else $error("column %0d carry-out not set by data count", j);
    end
  end

  assign sum_vec   = {1'b0, lo_bit};
  assign carry_vec = {hi_bit, 1'b0};

  if (FINAL_ADD) begin : g_add
    logic [RW:0] rc;
    assign rc[0] = 1'b0;
    for (genvar i = 0; i < RW; i++) begin : g_rip
      assign total[i] = sum_vec[i] ^ carry_vec[i] ^ rc[i];
      assign rc[i+1]  = (sum_vec[i] & carry_vec[i]) | (rc[i] & (sum_vec[i] ^ carry_vec[i]));
    end
    always_comb begin
      p_adder_no_overflow_r6: assert (rc[RW] == 1'b0)
        else $error("final adder carried out of the top bit");
    end
  end else begin : g_noadd
    assign total = '0;
  end

  logic [RW-1:0] exp_tot;
  always_comb begin
    exp_tot = '0;
    for (int k = 0; k < 6; k++) exp_tot = exp_tot + RW'(ops[k*W +: W]);
    p_pair_total_r4: assert (RW'(sum_vec + carry_vec) == exp_tot)
      else $error("redundant pair does not add to operand sum");
    p_edge_bits_clear_r5: assert (!carry_vec[0] && !sum_vec[RW-1])
      else $error("unused edge bit of the pair is set");
  end
endmodule

// File: tb/csa_row6_test.sv
`timescale 1ns/1ps
module csa_row6_test;
  localparam int W = 8;
  localparam int RW = W + 3;
  localparam int WS = 2;
  localparam int RS = WS + 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [6*W-1:0]  ops = '0, ops_r = '0;
  logic [RW-1:0]   sv, cv, tot, sv_r, cv_r, tot_r;
  logic [6*WS-1:0] ops_s = '0;
  logic [RS-1:0]   sv_s, cv_s, tot_s;

  csa_row6 #(.W(W), .FINAL_ADD(1'b1)) uut (.ops(ops), .sum_vec(sv), .carry_vec(cv), .total(tot));
  csa_row6 #(.W(W), .FINAL_ADD(1'b0)) uut_red (.ops(ops_r), .sum_vec(sv_r), .carry_vec(cv_r), .total(tot_r));
  csa_row6 #(.W(WS), .FINAL_ADD(1'b1)) uut_small (.ops(ops_s), .sum_vec(sv_s), .carry_vec(cv_s), .total(tot_s));

  int checks = 0, failures = 0;
  bit done = 1'b0;

  localparam logic [6*W-1:0] T_OPS [8] = '{
    48'h0,
    {6{8'hFF}},
    {8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1},
    {6{8'h80}},
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF},
    {8'hAA, 8'h55, 8'hAA, 8'h55, 8'hAA, 8'h55},
    {8'h02, 8'h01, 8'hCC, 8'h33, 8'hF0, 8'h0F},
    {6{8'h7F}}
  };
  localparam logic [RW-1:0] T_EXP [8] = '{
    11'd0, 11'd1530, 11'd21, 11'd768, 11'd255, 11'd765, 11'd513, 11'd762
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] ref_sum(input logic [6*W-1:0] v);
    logic [RW-1:0] s = '0;
    for (int k = 0; k < 6; k++) s = s + RW'(v[k*W +: W]);
    return s;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] hs, hc;
    @(negedge clk); #1;
    chk("R4 initial zero pair", 64'(RW'(sv + cv)), 64'd0);
    chk("R6 initial zero total", 64'(tot), 64'd0);

    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      ops = T_OPS[t];
      ops_r = T_OPS[t];
      #1;
      chk("R1 R4 table pair", 64'(RW'(sv + cv)), 64'(T_EXP[t]));
      chk("R6 table total", 64'(tot), 64'(T_EXP[t]));
      chk("R5 table edge bits", 64'({cv[0], sv[RW-1]}), 64'd0);
      chk("R7 table zero total", 64'(tot_r), 64'd0);
      chk("R7 table pair without adder", 64'(RW'(sv_r + cv_r)), 64'(T_EXP[t]));
    end

    // R8: all-ones operands, largest sum
    @(negedge clk); ops = {6{8'hFF}}; #1;
    chk("R8 max total", 64'(tot), 64'(6 * 255));
    chk("R8 max pair", 64'(RW'(sv + cv)), 64'(6 * 255));

    // R2 via exhaustive small row: every column sees all reachable carries
    for (int v = 0; v < 4096; v++) begin
      logic [RS-1:0] e;
      @(negedge clk);
      ops_s = 12'(v);
      #1;
      e = '0;
      for (int k = 0; k < 6; k++) e = e + RS'(ops_s[k*WS +: WS]);
      chk("R2 R4 exhaustive pair", 64'(RS'(sv_s + cv_s)), 64'(e));
      chk("R6 exhaustive total", 64'(tot_s), 64'(e));
    end

    // R3: toggling column 0 only must leave higher bits of the pair alone
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      ops = {$urandom, $urandom};
      ops_r = ops;
      #1;
      chk("R4 random pair", 64'(RW'(sv + cv)), 64'(ref_sum(ops)));
      chk("R6 random total", 64'(tot), 64'(ref_sum(ops)));
      chk("R7 random zero total", 64'(tot_r), 64'd0);
      hs = sv;
      hc = cv;
      @(negedge clk);
      for (int k = 0; k < 6; k++) ops[k*W] = ~ops[k*W];
      #1;
      chk("R3 upper low-weight bits unchanged", 64'(sv[RW-1:3]), 64'(hs[RW-1:3]));
      chk("R3 upper high-weight bits unchanged", 64'(cv[RW-1:4]), 64'(hc[RW-1:4]));
      chk("R4 toggled pair", 64'(RW'(sv + cv)), 64'(ref_sum(ops)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule